// File: doc/BRIEF.md
# Serial Test Port Controller with Status-Loading Instruction Register

This block is the serial test port of a chip: a sixteen-state controller advanced by the test clock `tck` and steered by the mode input `tms`, a 10-bit instruction register, an instruction decoder, and the small data registers that are reached through it. Bits enter on `tdi` and leave on `tdo`, which is launched on the falling edge of `tck` and qualified by `tdo_en`. `tdo_en` models the output's high-impedance control.

When an instruction scan starts, the instruction register loads a status word built from four flag inputs, so the test host reads device status while it shifts in the next opcode. The data registers inside the block are the single-bit bypass stage, a 32-bit identity word whose low twelve bits are fixed at 0x093, and a 32-bit user code that reads as all ones until it has been loaded. The boundary cell chain lives outside the block. The block drives its select, capture, shift and update strobes and takes the chain's serial return on `bsr_tdo`.

The controller states are named ST_RESET, ST_IDLE, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR and ST_UPD_IR. The transitions are listed below as state: next state when tms=0 / next state when tms=1.

- ST_RESET: ST_IDLE / ST_RESET
- ST_IDLE: ST_IDLE / ST_SEL_DR
- ST_SEL_DR: ST_CAP_DR / ST_SEL_IR
- ST_SEL_IR: ST_CAP_IR / ST_RESET
- ST_CAP_x: ST_SH_x / ST_EX1_x
- ST_SH_x: ST_SH_x / ST_EX1_x
- ST_EX1_x: ST_PA_x / ST_UPD_x
- ST_PA_x: ST_PA_x / ST_EX2_x
- ST_EX2_x: ST_SH_x / ST_UPD_x
- ST_UPD_x: ST_IDLE / ST_SEL_DR

In these rows x is DR or IR.

Top module: `scan_port_top`

## Requirements
- R1: When `por_n` is released, the controller is in ST_RESET, `tdo_en` is 0, and the active instruction is the identity opcode 0x009. A data scan made straight after reset therefore returns the identity word.
- R2: Five rising `tck` edges with `tms`=1 bring the controller to ST_RESET from any state, and ST_RESET reloads the identity opcode. While `tms` stays at 1, the controller stays in ST_RESET.
- R3: In ST_CAP_IR the instruction shift register loads the status word, which the host sees first in the order shifted out. Bit 0 is 1 and bit 1 is 0. Bit 2 is `flag_isc_done`, bit 3 is `flag_isc_en`, bit 4 is `flag_init_ok` and bit 5 is `flag_done`. Bits 9:6 are 0.
- R4: The instruction register shifts from `tdi` with the least significant bit first. A pause (ST_PA_IR and ST_EX2_IR) in the middle of a scan loses no bits. The active instruction changes only on the rising edge that leaves ST_UPD_IR, or in ST_RESET.
- R5: The bypass stage is one flip-flop that loads 0 in ST_CAP_DR. It is the data path for BYPASS (0x3FF), for HIGHZ (0x00A) and for every undefined opcode, so the first bit out is 0 and each later bit is `tdi` delayed by one shift.
- R6: With opcode 0x009, a 32-bit data scan returns the identity word, least significant bit first. Its bit 0 is 1 and its bits 11:0 are 0x093.
- R7: With opcode 0x008, a 32-bit data scan returns `ucode_word` when `ucode_loaded` is 1, and 0xFFFFFFFF when it is 0.
- R8: For EXTEST (0x000), SAMPLE/PRELOAD (0x001) and INTEST (0x007), `bsr_sel` is 1, and `bsr_capture`, `bsr_shift` and `bsr_update` pulse only in ST_CAP_DR, ST_SH_DR and ST_UPD_DR respectively. During the shift, `tdo` carries `bsr_tdo`. `extest_mode`, `intest_mode` and `highz_mode` are 1 exactly while EXTEST, INTEST or HIGHZ is the active instruction. Under any other instruction the strobes stay 0.
- R9: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 only while the controller is in ST_SH_IR or ST_SH_DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, launched on falling tck |
| tdo_en | output | 1 | Output enable for tdo (0 = high impedance) |
| flag_done | input | 1 | Status flag, captured into IR bit 5 |
| flag_init_ok | input | 1 | Status flag, captured into IR bit 4 |
| flag_isc_en | input | 1 | Status flag, captured into IR bit 3 |
| flag_isc_done | input | 1 | Status flag, captured into IR bit 2 |
| ucode_loaded | input | 1 | User code has been programmed |
| ucode_word | input | 32 | Programmed user code |
| bsr_tdo | input | 1 | Serial return from the external boundary chain |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary capture strobe |
| bsr_shift | output | 1 | Boundary shift strobe |
| bsr_update | output | 1 | Boundary update strobe |
| extest_mode | output | 1 | EXTEST instruction active |
| intest_mode | output | 1 | INTEST instruction active |
| highz_mode | output | 1 | HIGHZ instruction active |

## Verification
The bench aims at these corner cases:

- An instruction scan interrupted by a pause. A controller that shifted in ST_PA_IR or ST_EX2_IR would misalign the opcode, and the following data scan would return the wrong register.
- Undefined and HIGHZ opcodes. A decoder that fell through to the identity register would return 0x...093 where a one-bit delay of `tdi` is expected.
- The unprogrammed user code, which must read all ones rather than stale or zero data.
- Returning to ST_RESET from a random walk through the states. A design that failed to reload the identity opcode there would keep the old instruction.
- The timing of `tdo`. The bench compares `tdo` just before and just after each rising edge, so a design that launched it on the rising edge would show the change.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

    typedef enum logic [3:0] {
        ST_RESET,  ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DSEL_BYPASS,
        DSEL_IDENT,
        DSEL_UCODE,
        DSEL_BOUND
    } dr_sel_e;

    // Status word layout loaded in ST_CAP_IR
    localparam int CAP_FIXED_W = 2;
    localparam logic [CAP_FIXED_W-1:0] CAP_FIXED = 2'b01;
    localparam int CAP_FLAG_W  = 4;
    localparam int CAP_USED_W  = CAP_FIXED_W + CAP_FLAG_W;

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr
);

    tap_state_e nxt;

    // state register
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state <= ST_RESET;
        else        state <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // state decode outputs
    always_comb begin
        in_reset = 1'b0;
        cap_ir   = 1'b0;
        sh_ir    = 1'b0;
        upd_ir   = 1'b0;
        cap_dr   = 1'b0;
        sh_dr    = 1'b0;
        upd_dr   = 1'b0;
        unique case (state)
            ST_RESET:  in_reset = 1'b1;
            ST_CAP_IR: cap_ir   = 1'b1;
            ST_SH_IR:  sh_ir    = 1'b1;
            ST_UPD_IR: upd_ir   = 1'b1;
            ST_CAP_DR: cap_dr   = 1'b1;
            ST_SH_DR:  sh_dr    = 1'b1;
            ST_UPD_DR: upd_dr   = 1'b1;
            default: ;
        endcase
    end

    // R2: holding tms high keeps the controller parked in reset
    assert_reset_sticky_R2: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    // R2: from the select-IR state, tms high always lands in reset
    assert_sel_ir_exit_R2: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_SEL_IR && tms) |=> (state == ST_RESET));

endmodule

// File: rtl/scan_ir_unit.sv
`timescale 1ns/1ps
module scan_ir_unit
    import scan_pkg::*;
#(
    parameter int              IR_W     = 10,
    parameter logic [IR_W-1:0] OP_RESET = 10'h009
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            in_reset,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    input  logic            tdi,
    input  logic            flag_done,
    input  logic            flag_init_ok,
    input  logic            flag_isc_en,
    input  logic            flag_isc_done,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so
);

    localparam int RSV_W = IR_W - CAP_USED_W;

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] cap_word;

    always_comb begin
        cap_word = {{RSV_W{1'b0}}, flag_done, flag_init_ok, flag_isc_en,
                    flag_isc_done, CAP_FIXED};
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)       ir_sr <= '0;
        else if (cap_ir)  ir_sr <= cap_word;
        else if (sh_ir)   ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)        ir_q <= OP_RESET;
        else if (in_reset) ir_q <= OP_RESET;
        else if (upd_ir)   ir_q <= ir_sr;
    end

    assign ir_so = ir_sr[0];

    // R3: captured word has fixed low bits, zero reserved bits, live flags
    assert_status_capture_R3: assert property (@(posedge tck) disable iff (!por_n)
        cap_ir |=> (ir_sr[CAP_FIXED_W-1:0] == CAP_FIXED
                    && ir_sr[IR_W-1:CAP_USED_W] == '0
                    && ir_sr[CAP_USED_W-1] == $past(flag_done)
                    && ir_sr[CAP_FIXED_W]  == $past(flag_isc_done)));

    // R4: active instruction only moves on update or reset
    assert_ir_hold_R4: assert property (@(posedge tck) disable iff (!por_n)
        (!upd_ir && !in_reset) |=> $stable(ir_q));

    // R2: reset state loads the identity opcode
    assert_reset_opcode_R2: assert property (@(posedge tck) disable iff (!por_n)
        in_reset |=> (ir_q == OP_RESET));

endmodule

// File: rtl/scan_op_decode.sv
`timescale 1ns/1ps
module scan_op_decode
    import scan_pkg::*;
#(
    parameter int              IR_W      = 10,
    parameter logic [IR_W-1:0] OP_EXTEST = 10'h000,
    parameter logic [IR_W-1:0] OP_SAMPLE = 10'h001,
    parameter logic [IR_W-1:0] OP_INTEST = 10'h007,
    parameter logic [IR_W-1:0] OP_UCODE  = 10'h008,
    parameter logic [IR_W-1:0] OP_IDENT  = 10'h009,
    parameter logic [IR_W-1:0] OP_HIGHZ  = 10'h00A
) (
    input  logic [IR_W-1:0] ir_q,
    output dr_sel_e         dsel,
    output logic            extest_mode,
    output logic            intest_mode,
    output logic            highz_mode
);

    always_comb begin
        dsel        = DSEL_BYPASS;
        extest_mode = 1'b0;
        intest_mode = 1'b0;
        highz_mode  = 1'b0;
        if (ir_q == OP_EXTEST) begin
            dsel        = DSEL_BOUND;
            extest_mode = 1'b1;
        end else if (ir_q == OP_SAMPLE) begin
            dsel        = DSEL_BOUND;
        end else if (ir_q == OP_INTEST) begin
            dsel        = DSEL_BOUND;
            intest_mode = 1'b1;
        end else if (ir_q == OP_IDENT) begin
            dsel        = DSEL_IDENT;
        end else if (ir_q == OP_UCODE) begin
            dsel        = DSEL_UCODE;
        end else if (ir_q == OP_HIGHZ) begin
            highz_mode  = 1'b1;
        end
    end

    // R8: at most one test mode flag at a time
    always_comb begin
        assert_mode_exclusive_R8: assert ($onehot0({extest_mode, intest_mode, highz_mode}));
    end

endmodule

// File: rtl/scan_dr_unit.sv
`timescale 1ns/1ps
module scan_dr_unit
    import scan_pkg::*;
#(
    parameter int              DR_W  = 32,
    parameter logic [DR_W-1:0] IDENT = 32'h0A2D_6093
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            cap_dr,
    input  logic            sh_dr,
    input  dr_sel_e         dsel,
    input  logic            tdi,
    input  logic            ucode_loaded,
    input  logic [DR_W-1:0] ucode_word,
    input  logic            bsr_tdo,
    output logic            dr_so
);

    logic            byp;
    logic [DR_W-1:0] dr_sr;
    logic            wide_sel;

    assign wide_sel = (dsel == DSEL_IDENT) || (dsel == DSEL_UCODE);

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)      byp <= 1'b0;
        else if (cap_dr) byp <= 1'b0;
        else if (sh_dr)  byp <= tdi;
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            dr_sr <= '0;
        end else if (cap_dr && wide_sel) begin
            if (dsel == DSEL_IDENT)  dr_sr <= IDENT;
            else if (ucode_loaded)   dr_sr <= ucode_word;
            else                     dr_sr <= '1;
        end else if (sh_dr && wide_sel) begin
            dr_sr <= {tdi, dr_sr[DR_W-1:1]};
        end
    end

    always_comb begin
        unique case (dsel)
            DSEL_BOUND:             dr_so = bsr_tdo;
            DSEL_IDENT, DSEL_UCODE: dr_so = dr_sr[0];
            default:                dr_so = byp;
        endcase
    end

    // R5: bypass stage always starts a scan at zero
    assert_bypass_zero_R5: assert property (@(posedge tck) disable iff (!por_n)
        cap_dr |=> !byp);

    // R7: an unprogrammed user code captures as all ones
    assert_ucode_blank_R7: assert property (@(posedge tck) disable iff (!por_n)
        (cap_dr && dsel == DSEL_UCODE && !ucode_loaded) |=> (dr_sr == '1));

endmodule

// File: rtl/scan_port_top.sv
`timescale 1ns/1ps
module scan_port_top
    import scan_pkg::*;
#(
    parameter int                   IR_W      = 10,
    parameter int                   DR_W      = 32,
    parameter logic [DR_W-13:0]     ID_HIGH   = 'h0A2D6,
    parameter logic [IR_W-1:0]      OP_EXTEST = 10'h000,
    parameter logic [IR_W-1:0]      OP_SAMPLE = 10'h001,
    parameter logic [IR_W-1:0]      OP_INTEST = 10'h007,
    parameter logic [IR_W-1:0]      OP_UCODE  = 10'h008,
    parameter logic [IR_W-1:0]      OP_IDENT  = 10'h009,
    parameter logic [IR_W-1:0]      OP_HIGHZ  = 10'h00A
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_en,
    input  logic            flag_done,
    input  logic            flag_init_ok,
    input  logic            flag_isc_en,
    input  logic            flag_isc_done,
    input  logic            ucode_loaded,
    input  logic [DR_W-1:0] ucode_word,
    input  logic            bsr_tdo,
    output logic            bsr_sel,
    output logic            bsr_capture,
    output logic            bsr_shift,
    output logic            bsr_update,
    output logic            extest_mode,
    output logic            intest_mode,
    output logic            highz_mode
);

    localparam logic [11:0]     ID_LOW = 12'h093;
    localparam logic [DR_W-1:0] IDENT  = {ID_HIGH, ID_LOW};

    tap_state_e      state;
    logic            in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
    logic [IR_W-1:0] ir_q;
    logic            ir_so, dr_so;
    dr_sel_e         dsel;

    scan_tap_fsm u_fsm (
        .tck(tck), .por_n(por_n), .tms(tms), .state(state),
        .in_reset(in_reset), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr)
    );

    scan_ir_unit #(.IR_W(IR_W), .OP_RESET(OP_IDENT)) u_ir (
        .tck(tck), .por_n(por_n), .in_reset(in_reset), .cap_ir(cap_ir),
        .sh_ir(sh_ir), .upd_ir(upd_ir), .tdi(tdi),
        .flag_done(flag_done), .flag_init_ok(flag_init_ok),
        .flag_isc_en(flag_isc_en), .flag_isc_done(flag_isc_done),
        .ir_q(ir_q), .ir_so(ir_so)
    );

    scan_op_decode #(
        .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE),
        .OP_INTEST(OP_INTEST), .OP_UCODE(OP_UCODE), .OP_IDENT(OP_IDENT),
        .OP_HIGHZ(OP_HIGHZ)
    ) u_dec (
        .ir_q(ir_q), .dsel(dsel), .extest_mode(extest_mode),
        .intest_mode(intest_mode), .highz_mode(highz_mode)
    );

    scan_dr_unit #(.DR_W(DR_W), .IDENT(IDENT)) u_dr (
        .tck(tck), .por_n(por_n), .cap_dr(cap_dr), .sh_dr(sh_dr), .dsel(dsel),
        .tdi(tdi), .ucode_loaded(ucode_loaded), .ucode_word(ucode_word),
        .bsr_tdo(bsr_tdo), .dr_so(dr_so)
    );

    // boundary chain strobes
    assign bsr_sel     = (dsel == DSEL_BOUND);
    assign bsr_capture = bsr_sel && cap_dr;
    assign bsr_shift   = bsr_sel && sh_dr;
    assign bsr_update  = bsr_sel && upd_dr;

    // output stage launched on the falling edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= sh_ir ? ir_so : dr_so;
            tdo_en <= sh_ir || sh_dr;
        end
    end

    // R9: driver only enabled while a shift state is current
    assert_tdo_en_shift_R9: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R8: boundary strobes never overlap
    assert_bsr_strobe_R8: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0({bsr_capture, bsr_shift, bsr_update}));

endmodule

// File: tb/scan_port_top_test.sv
`timescale 1ns/1ps
module scan_port_top_test;

    localparam logic [9:0]  OP_EXTEST = 10'h000;
    localparam logic [9:0]  OP_SAMPLE = 10'h001;
    localparam logic [9:0]  OP_INTEST = 10'h007;
    localparam logic [9:0]  OP_UCODE  = 10'h008;
    localparam logic [9:0]  OP_IDENT  = 10'h009;
    localparam logic [9:0]  OP_HIGHZ  = 10'h00A;
    localparam logic [9:0]  OP_BYPASS = 10'h3FF;
    localparam logic [31:0] EXP_ID    = 32'h0A2D_6093;

    logic tck = 1'b0;
    logic por_n, tms, tdi, tdo, tdo_en;
    logic flag_done, flag_init_ok, flag_isc_en, flag_isc_done;
    logic ucode_loaded, bsr_tdo;
    logic [31:0] ucode_word;
    logic bsr_sel, bsr_capture, bsr_shift, bsr_update;
    logic extest_mode, intest_mode, highz_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 tck = ~tck;

    scan_port_top uut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .flag_done(flag_done), .flag_init_ok(flag_init_ok),
        .flag_isc_en(flag_isc_en), .flag_isc_done(flag_isc_done),
        .ucode_loaded(ucode_loaded), .ucode_word(ucode_word), .bsr_tdo(bsr_tdo),
        .bsr_sel(bsr_sel), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .extest_mode(extest_mode),
        .intest_mode(intest_mode), .highz_mode(highz_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_status(input logic d, input logic i,
                                              input logic e, input logic s);
        return {4'b0000, d, i, e, s, 2'b01};
    endfunction

    // 0 bypass, 1 identity, 2 user code, 3 boundary
    function automatic int kind_of(input logic [9:0] op);
        if (op == OP_EXTEST || op == OP_SAMPLE || op == OP_INTEST) return 3;
        if (op == OP_IDENT) return 1;
        if (op == OP_UCODE) return 2;
        return 0;
    endfunction

    // one tck cycle: sample outputs after falling edge, then apply tms/tdi
    task automatic step(input logic m, input logic d, output logic o,
                        output logic e, output logic bs);
        @(negedge tck); #1;
        o = tdo; e = tdo_en; bs = bsr_shift;
        tms = m; tdi = d;
        @(posedge tck); #0.5;
        chk(tdo === o && tdo_en === e, "R9 tdo held across rising edge",
            {62'd0, tdo_en, tdo}, {62'd0, e, o});
    endtask

    task automatic scan_ir(input logic [9:0] op, input int pause_at,
                           output logic [9:0] cap);
        logic o, e, bs;
        step(1'b1, 1'b0, o, e, bs);
        chk(!e, "R9 enable low in idle", {63'd0, e}, 64'd0);
        step(1'b1, 1'b0, o, e, bs);
        step(1'b0, 1'b0, o, e, bs);
        step(1'b0, 1'b0, o, e, bs);
        for (int i = 0; i < 10; i++) begin
            step((i == 9) || (pause_at != 0 && i == pause_at - 1), op[i], o, e, bs);
            cap[i] = o;
            chk(e === 1'b1, "R9 enable high in shift-IR", {63'd0, e}, 64'd1);
            if (pause_at != 0 && i == pause_at - 1) begin
                step(1'b0, 1'b0, o, e, bs);
                chk(!e, "R4 enable low in exit1-IR", {63'd0, e}, 64'd0);
                step(1'b0, 1'b1, o, e, bs);
                step(1'b1, 1'b1, o, e, bs);
                chk(!e, "R4 enable low in pause-IR", {63'd0, e}, 64'd0);
                step(1'b0, 1'b1, o, e, bs);
            end
        end
        step(1'b1, 1'b0, o, e, bs);
        step(1'b0, 1'b0, o, e, bs);
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din,
                           output logic [31:0] dout, output int bsc);
        logic o, e, bs;
        dout = '0;
        bsc = 0;
        step(1'b1, 1'b0, o, e, bs);
        step(1'b0, 1'b0, o, e, bs);
        step(1'b0, 1'b0, o, e, bs);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, e, bs);
            dout[i] = o;
            if (bs) bsc++;
        end
        step(1'b1, 1'b0, o, e, bs);
        step(1'b0, 1'b0, o, e, bs);
    endtask

    task automatic check_data(input logic [9:0] op);
        logic [31:0] din, dout, expv;
        int bsc, k, n;
        k = kind_of(op);
        din = $urandom;
        bsr_tdo = 1'($urandom_range(0, 1));
        n = (k == 0) ? 16 : (k == 3 ? 12 : 32);
        scan_dr(n, din, dout, bsc);
        case (k)
            0: begin
                expv = {din[30:0], 1'b0} & 32'h0000_FFFF;
                chk(dout == expv, "R5 bypass delay", {32'd0, dout}, {32'd0, expv});
            end
            1: begin
                chk(dout == EXP_ID, "R6 identity word", {32'd0, dout}, {32'd0, EXP_ID});
                chk(dout[0] && dout[11:0] == 12'h093, "R6 identity low bits",
                    {52'd0, dout[11:0]}, 64'h093);
            end
            2: begin
                expv = ucode_loaded ? ucode_word : 32'hFFFF_FFFF;
                chk(dout == expv, "R7 user code", {32'd0, dout}, {32'd0, expv});
            end
            default: begin
                expv = bsr_tdo ? 32'h0000_0FFF : 32'h0;
                chk(dout == expv, "R8 boundary return", {32'd0, dout}, {32'd0, expv});
            end
        endcase
        chk(bsc == ((k == 3) ? n : 0), "R8 shift strobe count", 64'(bsc),
            64'((k == 3) ? n : 0));
    endtask

    task automatic check_modes(input logic [9:0] op);
        logic [3:0] act, expv;
        act  = {bsr_sel, extest_mode, intest_mode, highz_mode};
        expv = {kind_of(op) == 3, op == OP_EXTEST, op == OP_INTEST, op == OP_HIGHZ};
        chk(act == expv, "R8 mode outputs", {60'd0, act}, {60'd0, expv});
    endtask

    task automatic set_flags(input logic [3:0] f);
        {flag_done, flag_init_ok, flag_isc_en, flag_isc_done} = f;
    endtask

    task automatic ir_case(input logic [9:0] op, input int pause_at);
        logic [9:0] cap, expv;
        expv = exp_status(flag_done, flag_init_ok, flag_isc_en, flag_isc_done);
        scan_ir(op, pause_at, cap);
        chk(cap == expv, "R3 status capture", {54'd0, cap}, {54'd0, expv});
        check_modes(op);
        check_data(op);
    endtask

    initial begin
        logic o, e, bs;
        logic [31:0] dout;
        int bsc;
        logic [9:0] op;
        void'($urandom(32'd2024));
        por_n = 1'b0; tms = 1'b1; tdi = 1'b0; bsr_tdo = 1'b0;
        set_flags(4'b0000);
        ucode_loaded = 1'b0; ucode_word = 32'h0;
        repeat (3) @(posedge tck);
        #1 por_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, o, e, bs);
            chk(!e, "R1 enable low after reset", {63'd0, e}, 64'd0);
        end
        step(1'b0, 1'b0, o, e, bs);
        scan_dr(32, 32'h1234_5678, dout, bsc);
        chk(dout == EXP_ID, "R1 identity selected after reset", {32'd0, dout},
            {32'd0, EXP_ID});

        // directed corners
        set_flags(4'b1111);
        ir_case(OP_BYPASS, 0);
        set_flags(4'b1010);
        ucode_loaded = 1'b0;
        ir_case(OP_UCODE, 5);          // R4 paused scan, R7 blank code
        ucode_loaded = 1'b1; ucode_word = 32'hC0DE_0017;
        ir_case(OP_UCODE, 3);
        set_flags(4'b0101);
        ir_case(10'h155, 0);           // R5 undefined opcode
        ir_case(OP_HIGHZ, 0);          // R5 HIGHZ uses bypass
        ir_case(OP_EXTEST, 0);
        ir_case(OP_IDENT, 8);

        // constrained random
        for (int it = 0; it < 40; it++) begin
            set_flags(4'($urandom));
            ucode_loaded = 1'($urandom_range(0, 1));
            ucode_word = $urandom;
            case ($urandom_range(0, 7))
                0: op = OP_EXTEST;
                1: op = OP_SAMPLE;
                2: op = OP_INTEST;
                3: op = OP_BYPASS;
                4: op = OP_IDENT;
                5: op = OP_UCODE;
                6: op = OP_HIGHZ;
                default: begin
                    op = 10'($urandom);
                    if (op <= OP_HIGHZ) op = 10'h2A0 | op;
                end
            endcase
            ir_case(op, (it % 3 == 0) ? int'($urandom_range(1, 9)) : 0);
        end

        // R2: random walk then five tms ones
        for (int w = 0; w < 4; w++) begin
            scan_ir(OP_BYPASS, 0, op);
            for (int i = 0; i < 24; i++)
                step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), o, e, bs);
            for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e, bs);
            step(1'b0, 1'b0, o, e, bs);
            chk(!e, "R2 enable low after return to reset", {63'd0, e}, 64'd0);
            scan_dr(32, $urandom, dout, bsc);
            chk(dout == EXP_ID, "R2 identity reloaded by reset", {32'd0, dout},
                {32'd0, EXP_ID});
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tck);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule